// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is a small test engine that sits behind a bus endpoint so a host can exercise the link and its own driver. The host reaches it through eight word registers on a simple register bus. Through them it can check plain register access, start one job at a time and read back the result. A job either raises an interrupt of a chosen kind and vector, or moves data through a memory request port. Data jobs read a host buffer, fill a host buffer with a known pattern, or copy one host buffer to another.

Before any memory access, every data job checks its address span against a legal window. On completion the job records success or failure in sticky status bits. If the host has set a legal interrupt kind and vector, the job also pulses an interrupt output for one cycle. Interrupt requests with an illegal kind/vector pairing are dropped without a pulse.

Top module: `eptest_engine`

## Requirements
- R1: Register index 0 is a 32-bit scratch register: any value written to it reads back unchanged.
- R2: Register index 1 holds the command. Bit 0 asks for a legacy interrupt, bit 1 for MSI and bit 2 for MSI-X. Bit 3 starts a read job, bit 4 a write job and bit 5 a copy job. A write is accepted only if exactly one of bits [5:0] is set and bits [31:6] are zero. Other writes are ignored and start nothing. While a job runs the register reads back the accepted command, and it reads 0 once the job completes.
- R3: Register index 2 is status: bit 0 read ok, bit 1 read fail, bit 2 write ok, bit 3 write fail, bit 4 copy ok, bit 5 copy fail, bit 6 interrupt raised, bit 7 bad source span, bit 8 bad destination span. Bits are sticky and any write to index 2 clears them all. A completion in the same cycle still sets its bits.
- R4: A read job issues ceil(size/4) word reads at source (index 3) + 4k for k = 0, 1, ... in order, where size is the byte count in index 5, then sets status bit 0.
- R5: A write job writes the word scratch + k to destination (index 4) + 4k for each beat k, then sets status bit 2.
- R6: A copy job reads source + 4k and then writes that word to destination + 4k before the next beat, then sets status bit 4.
- R7: Interrupt kind is coded 0 legacy, 1 MSI, 2 MSI-X. The vector (index 7, full 32 bits) is legal only as 0 for legacy, 1..32 for MSI and 1..2048 for MSI-X. An interrupt command uses the kind named by its command bit, and it raises an interrupt only for a legal pairing.
- R8: When a data job ends, success or fail, the interrupt pulses for exactly one cycle. The pulse carries the kind from index 6 (2 bits) and the vector from index 7, and it sets status bit 6. If the pairing is illegal, or the kind is 3, there is no pulse and bit 6 stays clear.
- R9: A span [addr, addr + 4*ceil(size/4)) that does not lie inside [0x1000, 0x1400) is rejected. The job then sets the bad source or bad destination bit and the job's fail bit, and it issues no memory access.
- R10: A job whose span is legal and whose size is 0 issues no access and sets its success bit.
- R11: A memory request keeps valid, address and direction stable until ready. A read beat completes when the response strobe arrives.
- R12: A command write while a job is running is ignored and does not disturb the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | AW | Byte address of the word |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_rdata | input | DW | Read response data |
| irq_pulse | output | 1 | One-cycle interrupt strobe |
| irq_kind | output | 2 | Interrupt kind for the pulse |
| irq_vec | output | VECW | Interrupt vector for the pulse |

## Verification
The hardest case to reach from the ports is a command write that lands while a job is still running. The bench reaches it with a 64-byte read, whose ready line is stalled on a periodic pattern, and sends a second command straight after the first. The other awkward corner is a span whose byte size fits the window but whose rounded-up beat count does not. The bench aims a 5-byte write four bytes below the window end to hit it, and places a 16-byte write exactly at the end for the passing side.

// File: rtl/eptest_engine.sv
module eptest_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SZW = 16,
  parameter logic [AW-1:0] WIN_BASE = 'h1000,
  parameter logic [AW-1:0] WIN_END = 'h1400,
  parameter int MSI_TOP = 32,
  parameter int MSIX_TOP = 2048,
  parameter int VECW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_rdata,
  output logic            irq_pulse,
  output logic [1:0]      irq_kind,
  output logic [VECW-1:0] irq_vec
);
  localparam int WB = DW / 8;
  localparam int WSH = $clog2(WB);

  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_RDREQ, S_RDWAIT, S_WRREQ, S_DONE} st_t;

  st_t           st_q;
  logic [31:0]   scratch_q, vecn_q;
  logic [5:0]    opc_q;
  logic [8:0]    stat_q, res_q;
  logic [AW-1:0] src_q, dst_q;
  logic [SZW-1:0] size_q;
  logic [1:0]    kind_q;
  logic [SZW:0]  cnt_q;
  logic [DW-1:0] buf_q;

  function automatic logic vec_legal(input logic [1:0] k, input logic [31:0] n);
    case (k)
      2'd0:    return n == 32'd0;
      2'd1:    return n >= 32'd1 && n <= 32'(MSI_TOP);
      2'd2:    return n >= 32'd1 && n <= 32'(MSIX_TOP);
      default: return 1'b0;
    endcase
  endfunction

  logic is_rd, is_wr, is_cp, irq_cmd, cmd_acc, clr, bad_s, bad_d, fire, last;
  logic [SZW:0] beats;
  logic [AW:0]  span, src_end, dst_end;
  logic [8:0]   ok_bits, bad_bits;
  logic [1:0]   want_kind;

  assign is_rd   = opc_q[3];
  assign is_wr   = opc_q[4];
  assign is_cp   = opc_q[5];
  assign irq_cmd = |opc_q[2:0];
  assign cmd_acc = reg_we && reg_addr == 3'd1 && st_q == S_IDLE &&
                   $onehot(reg_wdata[5:0]) && reg_wdata[31:6] == '0;
  assign clr     = reg_we && reg_addr == 3'd2;

  assign beats   = ({1'b0, size_q} + (SZW+1)'(WB - 1)) >> WSH;
  assign span    = (AW+1)'(beats) << WSH;
  assign src_end = {1'b0, src_q} + span;
  assign dst_end = {1'b0, dst_q} + span;
  assign bad_s   = (is_rd || is_cp) && (src_q < WIN_BASE || src_end > {1'b0, WIN_END});
  assign bad_d   = (is_wr || is_cp) && (dst_q < WIN_BASE || dst_end > {1'b0, WIN_END});
  assign ok_bits  = {4'b0, is_cp, 1'b0, is_wr, 1'b0, is_rd};
  assign bad_bits = {bad_d, bad_s, 1'b0, is_cp, 1'b0, is_wr, 1'b0, is_rd, 1'b0};
  assign last     = (cnt_q + 1'b1) == beats;

  assign want_kind = opc_q[0] ? 2'd0 : opc_q[1] ? 2'd1 : opc_q[2] ? 2'd2 : kind_q;
  assign fire      = st_q == S_DONE && vec_legal(want_kind, vecn_q);
  assign irq_pulse = fire;
  assign irq_kind  = want_kind;
  assign irq_vec   = vecn_q[VECW-1:0];

  assign mem_req_valid = st_q == S_RDREQ || st_q == S_WRREQ;
  assign mem_req_write = st_q == S_WRREQ;
  assign mem_req_addr  = (st_q == S_WRREQ ? dst_q : src_q) + (AW'(cnt_q) << WSH);
  assign mem_req_wdata = is_cp ? buf_q : DW'(scratch_q) + DW'(cnt_q);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = scratch_q;
      3'd1:    reg_rdata = {26'b0, opc_q};
      3'd2:    reg_rdata = {23'b0, stat_q};
      3'd3:    reg_rdata = 32'(src_q);
      3'd4:    reg_rdata = 32'(dst_q);
      3'd5:    reg_rdata = 32'(size_q);
      3'd6:    reg_rdata = {30'b0, kind_q};
      default: reg_rdata = vecn_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      scratch_q <= '0;
      vecn_q    <= '0;
      opc_q     <= '0;
      stat_q    <= '0;
      res_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      size_q    <= '0;
      kind_q    <= '0;
      cnt_q     <= '0;
      buf_q     <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0:    scratch_q <= reg_wdata;
          3'd3:    src_q     <= AW'(reg_wdata);
          3'd4:    dst_q     <= AW'(reg_wdata);
          3'd5:    size_q    <= SZW'(reg_wdata);
          3'd6:    kind_q    <= reg_wdata[1:0];
          3'd7:    vecn_q    <= reg_wdata;
          default: ;
        endcase
      end

      if (st_q == S_DONE)
        stat_q <= (clr ? '0 : stat_q) | res_q | {2'b0, fire, 6'b0};
      else if (clr)
        stat_q <= '0;

      case (st_q)
        S_IDLE: if (cmd_acc) begin
          opc_q <= reg_wdata[5:0];
          st_q  <= S_EVAL;
        end
        S_EVAL: begin
          cnt_q <= '0;
          if (irq_cmd) begin
            res_q <= '0;
            st_q  <= S_DONE;
          end else if (bad_s || bad_d) begin
            res_q <= bad_bits;
            st_q  <= S_DONE;
          end else if (beats == '0) begin
            res_q <= ok_bits;
            st_q  <= S_DONE;
          end else begin
            st_q <= is_wr ? S_WRREQ : S_RDREQ;
          end
        end
        S_RDREQ: if (mem_req_ready) st_q <= S_RDWAIT;
        S_RDWAIT: if (mem_rsp_valid) begin
          buf_q <= mem_rsp_rdata;
          if (is_cp) begin
            st_q <= S_WRREQ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
              res_q <= ok_bits;
              st_q  <= S_DONE;
            end else begin
              st_q <= S_RDREQ;
            end
          end
        end
        S_WRREQ: if (mem_req_ready) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            res_q <= ok_bits;
            st_q  <= S_DONE;
          end else begin
            st_q <= is_cp ? S_RDREQ : S_WRREQ;
          end
        end
        S_DONE: begin
          opc_q <= '0;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eptest_engine_chk.sv
module eptest_engine_chk #(
  parameter int AW = 32,
  parameter int VECW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_pulse,
  input logic [1:0]      irq_kind,
  input logic [VECW-1:0] irq_vec,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [AW-1:0]   mem_req_addr,
  input logic [5:0]      opc,
  input logic [8:0]      stat
);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |=> !irq_pulse);
  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |=> stat[6]);
  // R7
  legacy_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse && irq_kind == 2'd0 |-> irq_vec == '0);
  // R7
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |-> irq_kind != 2'd3);
  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> opc != '0);
  // R2
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(opc));
endmodule

bind eptest_engine eptest_engine_chk #(.AW(AW), .VECW(VECW)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .irq_kind(irq_kind), .irq_vec(irq_vec),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .opc(opc_q), .stat(stat_q)
);

// File: tb/eptest_engine_tb_top.sv
module eptest_engine_tb_top;
  logic clk = 0;
  always #10 clk = ~clk;

  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_rdata = 0;
  logic        irq_pulse;
  logic [1:0]  irq_kind;
  logic [11:0] irq_vec;

  eptest_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata), .irq_pulse(irq_pulse),
    .irq_kind(irq_kind), .irq_vec(irq_vec)
  );

  typedef struct packed { logic wr; logic [31:0] a; logic [31:0] d; } acc_t;
  typedef struct packed { logic [1:0] k; logic [11:0] v; } irqe_t;
  acc_t  expq[$];
  irqe_t irqq[$];
  logic [31:0] mem [0:255];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "R11";
  logic pend = 0;
  logic [31:0] pend_d = 0;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // memory side and per-cycle comparison against the expected queues
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 0;
    if (pend) begin
      mem_rsp_valid = 1;
      mem_rsp_rdata = pend_d;
      pend = 0;
    end
    mem_req_ready = (cyc % 3) != 1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      logic [31:0] off;
      off = mem_req_addr - 32'h1000;
      if (expq.size() == 0) begin
        chk({tag, " unexpected access"}, mem_req_addr, 32'hFFFF_FFFF);
      end else begin
        acc_t e;
        e = expq.pop_front();
        chk({tag, " access dir"}, 32'(mem_req_write), 32'(e.wr));
        chk({tag, " access addr"}, mem_req_addr, e.a);
        if (e.wr) chk({tag, " write data"}, mem_req_wdata, e.d);
      end
      if (mem_req_write) mem[off[9:2]] = mem_req_wdata;
      else begin pend = 1; pend_d = mem[off[9:2]]; end
    end
    if (rst_n && irq_pulse) begin
      if (irqq.size() == 0) begin
        chk({tag, " unexpected irq"}, {18'b0, irq_kind, irq_vec}, 32'hFFFF_FFFF);
      end else begin
        irqe_t e;
        e = irqq.pop_front();
        chk({tag, " irq kind"}, 32'(irq_kind), 32'(e.k));
        chk({tag, " irq vec"}, 32'(irq_vec), 32'(e.v));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin rd(3'd1, v); n++; end while (v != 0 && n < 2000);
  endtask

  task automatic cfg(input logic [31:0] s, input logic [31:0] dd, input logic [31:0] sz,
                     input logic [31:0] k, input logic [31:0] vn);
    wr(3'd3, s); wr(3'd4, dd); wr(3'd5, sz); wr(3'd6, k); wr(3'd7, vn);
  endtask

  task automatic job(input string t, input logic [31:0] cmd, input logic [31:0] expstat, input bit clear);
    logic [31:0] v;
    tag = t;
    wr(3'd1, cmd);
    wait_idle();
    repeat (2) @(negedge clk);
    rd(3'd2, v);
    chk({t, " status"}, v, expstat);
    chk({t, " accesses left"}, 32'(expq.size()), 0);
    chk({t, " irqs left"}, 32'(irqq.size()), 0);
    if (clear) wr(3'd2, 32'h0);
  endtask

  function automatic irqe_t mk(input logic [1:0] k, input logic [11:0] v);
    irqe_t e; e.k = k; e.v = v; return e;
  endfunction

  function automatic acc_t ac(input logic w, input logic [31:0] a, input logic [31:0] d);
    acc_t e; e.wr = w; e.a = a; e.d = d; return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] magic;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i;
    repeat (3) @(negedge clk);
    chk("R8 reset irq", 32'(irq_pulse), 0);
    chk("R11 reset req", 32'(mem_req_valid), 0);
    rst_n = 1;
    rd(3'd2, v); chk("R3 reset status", v, 0);
    rd(3'd1, v); chk("R2 reset command", v, 0);
    rd(3'd0, v); chk("R1 reset scratch", v, 0);

    // R1
    wr(3'd0, 32'hA5A5_0000); rd(3'd0, v); chk("R1 scratch", v, 32'hA5A5_0000);
    magic = 32'h5A5A_FFFF;
    wr(3'd0, magic); rd(3'd0, v); chk("R1 scratch", v, magic);

    // R4 read job, MSI vector 5
    cfg(32'h1000, 32'h1100, 16, 1, 5);
    for (int k = 0; k < 4; k++) expq.push_back(ac(0, 32'h1000 + 4*k, 0));
    irqq.push_back(mk(1, 5));
    job("R4", 32'h08, 32'h041, 1);

    // R5 write job, 10 bytes -> 3 beats, MSI-X vector 2048
    cfg(32'h1000, 32'h1100, 10, 2, 2048);
    for (int k = 0; k < 3; k++) expq.push_back(ac(1, 32'h1100 + 4*k, magic + k));
    irqq.push_back(mk(2, 12'h800));
    job("R5", 32'h10, 32'h044, 1);

    // R6 copy, legacy
    cfg(32'h1100, 32'h1200, 12, 0, 0);
    for (int k = 0; k < 3; k++) begin
      expq.push_back(ac(0, 32'h1100 + 4*k, 0));
      expq.push_back(ac(1, 32'h1200 + 4*k, magic + k));
    end
    irqq.push_back(mk(0, 0));
    job("R6", 32'h20, 32'h050, 1);
    chk("R6 copied word", mem[8'h82], magic + 2);

    // R9 spans
    cfg(32'h1000, 32'h13F8, 16, 0, 0);
    irqq.push_back(mk(0, 0));
    job("R9 copy bad dst", 32'h20, 32'h160, 1);
    cfg(32'h0FFC, 32'h1000, 4, 0, 0);
    irqq.push_back(mk(0, 0));
    job("R9 read bad src", 32'h08, 32'h0C2, 1);
    cfg(32'h1000, 32'h13FC, 5, 0, 0);
    irqq.push_back(mk(0, 0));
    job("R9 rounded span", 32'h10, 32'h148, 1);
    cfg(32'h1000, 32'h13F0, 16, 0, 0);
    for (int k = 0; k < 4; k++) expq.push_back(ac(1, 32'h13F0 + 4*k, magic + k));
    irqq.push_back(mk(0, 0));
    job("R9 edge span", 32'h10, 32'h044, 1);

    // R10 size zero
    cfg(32'h1000, 32'h1000, 0, 0, 0);
    irqq.push_back(mk(0, 0));
    job("R10 size0", 32'h10, 32'h044, 1);
    cfg(32'h1000, 32'h2000, 0, 0, 0);
    irqq.push_back(mk(0, 0));
    job("R10 size0 bad dst", 32'h10, 32'h148, 1);

    // R7 interrupt commands, kind register set to 3 to show it is not used
    cfg(32'h1000, 32'h1000, 4, 3, 33);
    job("R7 msi 33", 32'h02, 32'h000, 1);
    wr(3'd7, 32); irqq.push_back(mk(1, 32));
    job("R7 msi 32", 32'h02, 32'h040, 1);
    wr(3'd7, 0);
    job("R7 msix 0", 32'h04, 32'h000, 1);
    wr(3'd7, 2049);
    job("R7 msix 2049", 32'h04, 32'h000, 1);
    wr(3'd7, 2048); irqq.push_back(mk(2, 12'h800));
    job("R7 msix 2048", 32'h04, 32'h040, 1);
    wr(3'd7, 3);
    job("R7 legacy 3", 32'h01, 32'h000, 1);
    wr(3'd7, 0); irqq.push_back(mk(0, 0));
    job("R7 legacy 0", 32'h01, 32'h040, 1);

    // R8 illegal completion kind / pairing
    cfg(32'h1000, 32'h1000, 4, 3, 0);
    expq.push_back(ac(1, 32'h1000, magic));
    job("R8 kind3", 32'h10, 32'h004, 1);
    cfg(32'h1000, 32'h1000, 4, 1, 0);
    expq.push_back(ac(1, 32'h1000, magic));
    job("R8 msi vec0", 32'h10, 32'h004, 1);

    // R3 sticky and clear
    cfg(32'h1000, 32'h1000, 4, 3, 0);
    expq.push_back(ac(0, 32'h1000, 0));
    job("R3 sticky a", 32'h08, 32'h001, 0);
    expq.push_back(ac(1, 32'h1000, magic));
    job("R3 sticky b", 32'h10, 32'h005, 0);
    wr(3'd2, 32'h1FF); rd(3'd2, v); chk("R3 clear", v, 0);

    // R2 ignored command words
    tag = "R2";
    wr(3'd1, 32'h18); rd(3'd1, v); chk("R2 two bits", v, 0);
    wr(3'd1, 32'h40); rd(3'd1, v); chk("R2 upper bit", v, 0);
    wr(3'd1, 32'h0);  rd(3'd1, v); chk("R2 zero", v, 0);
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk("R2 status after ignored", v, 0);

    // R12 command while busy
    cfg(32'h1000, 32'h1000, 64, 3, 0);
    for (int k = 0; k < 16; k++) expq.push_back(ac(0, 32'h1000 + 4*k, 0));
    tag = "R12";
    wr(3'd1, 32'h08);
    wr(3'd1, 32'h10);
    rd(3'd1, v); chk("R12 command held", v, 32'h08);
    wait_idle();
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R12 status", v, 32'h001);
    chk("R12 accesses left", 32'(expq.size()), 0);

    done = 1;
    summary();
  end
endmodule